// File: doc/BRIEF.md
# CPU Bus Acknowledge Gate

This block sits on the bus between a chipset model and a 68000-style CPU core. The chipset can signal its data acknowledge before the address it presents has switched to its final, remapped value. The gate therefore never passes that early acknowledge straight to the CPU. An access is qualified only when the chipset's output-enable and its acknowledge are both low in the same cycle, which marks a CPU read rather than a DMA cycle. The gate then waits for the memory side, either for a fixed number of cycles or until a read-valid pulse arrives, and only then lets the acknowledge through. It keeps forwarding that acknowledge until the chipset withdraws it.

Alongside the handshake, the block does three things. It issues a one-cycle read strobe on each falling edge of output-enable. It applies the boot overlay to the chipset's 22-bit word address, so that low addresses land in the ROM region at word 0x3C0000 and the reset vectors come from ROM. It captures the returned read word and holds it steady for the CPU while the acknowledge is being given.

Top module: `cpu_ack_gate`

## Requirements
- R1: While reset is held, `dtack_n` is 1, `mem_rd_req` is 0 and `cpu_rd_data` is 0. Reset also turns the overlay back on, so chip address 0 then maps to 0x3C0000.
- R2: `dtack_n` is 1 in every cycle where the gate is not in its acknowledge state. An early acknowledge that arrives while `oe_n` is high never drives `dtack_n` low.
- R3: The gate leaves idle only at a rising edge where `oe_n` is 0 and `ack_early_n` is 0.
- R4: With `WAIT_MODE`=0, call the qualifying edge E. The gate waits for `WAIT_CYCLES` (default 2) further edges and enters the acknowledge state at edge E+`WAIT_CYCLES`. Before that edge `dtack_n` is 1.
- R5: In the acknowledge state, `dtack_n` equals `ack_early_n` in the same cycle. The gate returns to idle at the first edge where `ack_early_n` is 1.
- R6: With `WAIT_MODE`=1, the gate stays in its wait state until an edge where `mem_rd_valid` is 1. From the next cycle it is in the acknowledge state.
- R7: `mem_rd_req` is 1 for exactly the one cycle after an edge at which `oe_n` is sampled 0, when it was sampled 1 at the edge before. At all other times it is 0.
- R8: While the overlay is on, a chip address whose bits [21:18] are all zero maps to `chip_addr + 0x3C0000`. For example, word 2 maps to 0x3C0002 and word 4 maps to 0x3C0004. All other addresses pass through unchanged.
- R9: When `overlay_clr` is sampled 1 at an edge, `mem_addr` equals `chip_addr` from the next cycle on. This holds until the next reset.
- R10: `cpu_rd_data` loads `mem_rd_data` at an edge where `mem_rd_valid` is 1 and the gate is not in the acknowledge state. Read-valid pulses that arrive during the acknowledge state are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oe_n | input | 1 | Chipset output-enable, active low |
| ack_early_n | input | 1 | Chipset early data acknowledge, active low |
| chip_addr | input | ADDR_W | Chipset word address |
| overlay_clr | input | 1 | Turns the boot overlay off from the next cycle |
| mem_rd_valid | input | 1 | Memory read data valid pulse |
| mem_rd_data | input | DATA_W | Memory read data |
| dtack_n | output | 1 | Gated acknowledge to the CPU, active low |
| mem_rd_req | output | 1 | One-cycle memory read strobe |
| mem_addr | output | ADDR_W | Address after the overlay remap |
| cpu_rd_data | output | DATA_W | Captured read word for the CPU |

## Verification
The bench targets the following corner cases.

- **Early acknowledge with `oe_n` high.** A gate that forwarded this acknowledge would hand the CPU data from the stale address before the remap.
- **Exact wait length in fixed mode.** A counter that is off by one would make `dtack_n` fall one cycle early or one cycle late.
- **Ready mode with a long stall.** A gate that stopped waiting on the cycle count would acknowledge before the data exists.
- **Read-valid pulse during the acknowledge state.** A missing hold would let the word change under the CPU.
- **Withdrawn acknowledge.** The bench checks that `dtack_n` rises in the same cycle the chipset withdraws its acknowledge.
- **Overlay window edges and timing.** The bench checks the edges of the overlay window and the one-cycle delay of `overlay_clr`.
- **Overlay after reset.** The bench checks that the overlay comes back on after a reset.

// File: rtl/cag_pkg.sv
package cag_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ACK  = 2'd2
  } ack_state_e;
endpackage

// File: rtl/cag_ack_fsm.sv
module cag_ack_fsm #(
  parameter int WAIT_MODE   = 0,
  parameter int WAIT_CYCLES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  oe_n,
  input  logic                  ack_early_n,
  input  logic                  mem_rd_valid,
  output cag_pkg::ack_state_e   state_o,
  output logic                  dtack_n
);
  import cag_pkg::*;

  localparam int CNT_W = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES) : 1;

  ack_state_e state_q, state_d;
  logic       wait_done;

  generate
    if (WAIT_MODE == 0) begin : g_fixed
      logic [CNT_W-1:0] cnt_q, cnt_d;

      assign wait_done = (cnt_q == CNT_W'(WAIT_CYCLES - 1));

      always_comb begin
        cnt_d = cnt_q;
        if (state_q == ST_IDLE)
          cnt_d = '0;
        else if (state_q == ST_WAIT && !wait_done)
          cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end
    end else begin : g_ready
      assign wait_done = mem_rd_valid;
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (!oe_n && !ack_early_n) state_d = ST_WAIT;
      ST_WAIT: if (wait_done)             state_d = ST_ACK;
      ST_ACK:  if (ack_early_n)           state_d = ST_IDLE;
      default:                            state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
  assign dtack_n = (state_q == ST_ACK) ? ack_early_n : 1'b1;
endmodule

// File: rtl/cag_addr_overlay.sv
module cag_addr_overlay #(
  parameter int                ADDR_W   = 22,
  parameter int                OVL_W    = 18,
  parameter logic [ADDR_W-1:0] ROM_BASE = 22'h3C0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              overlay_clr,
  input  logic [ADDR_W-1:0] chip_addr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              ovl_on
);
  logic ovl_q, ovl_d;
  logic in_win;

  generate
    if (OVL_W >= ADDR_W) begin : g_full
      assign in_win = 1'b1;
    end else begin : g_part
      assign in_win = (chip_addr[ADDR_W-1:OVL_W] == '0);
    end
  endgenerate

  assign ovl_d = ovl_q & ~overlay_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovl_q <= 1'b1;
    else        ovl_q <= ovl_d;
  end

  // ROM_BASE has its low OVL_W bits clear, so an OR acts as the add
  assign mem_addr = (ovl_q && in_win) ? (chip_addr | ROM_BASE) : chip_addr;
  assign ovl_on   = ovl_q;
endmodule

// File: rtl/cag_rd_path.sv
module cag_rd_path #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              oe_n,
  input  logic              mem_rd_valid,
  input  logic [DATA_W-1:0] mem_rd_data,
  input  logic              hold,
  output logic              mem_rd_req,
  output logic [DATA_W-1:0] rd_data
);
  logic              oe_q;
  logic              req_q, req_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              data_en;

  assign req_d   = oe_q & ~oe_n;
  assign data_en = mem_rd_valid & ~hold;
  assign data_d  = data_en ? mem_rd_data : data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q   <= 1'b1;
      req_q  <= 1'b0;
      data_q <= '0;
    end else begin
      oe_q   <= oe_n;
      req_q  <= req_d;
      data_q <= data_d;
    end
  end

  assign mem_rd_req = req_q;
  assign rd_data    = data_q;
endmodule

// File: rtl/cpu_ack_gate.sv
module cpu_ack_gate #(
  parameter int                ADDR_W      = 22,
  parameter int                DATA_W      = 16,
  parameter int                OVL_W       = 18,
  parameter logic [ADDR_W-1:0] ROM_BASE    = 22'h3C0000,
  parameter int                WAIT_MODE   = 0,
  parameter int                WAIT_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              oe_n,
  input  logic              ack_early_n,
  input  logic [ADDR_W-1:0] chip_addr,
  input  logic              overlay_clr,
  input  logic              mem_rd_valid,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              dtack_n,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] cpu_rd_data
);
  import cag_pkg::*;

  ack_state_e state_w;
  logic       ovl_on_w;
  logic       in_ack_w;

  assign in_ack_w = (state_w == ST_ACK);

  cag_ack_fsm #(
    .WAIT_MODE   (WAIT_MODE),
    .WAIT_CYCLES (WAIT_CYCLES)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .oe_n         (oe_n),
    .ack_early_n  (ack_early_n),
    .mem_rd_valid (mem_rd_valid),
    .state_o      (state_w),
    .dtack_n      (dtack_n)
  );

  cag_addr_overlay #(
    .ADDR_W   (ADDR_W),
    .OVL_W    (OVL_W),
    .ROM_BASE (ROM_BASE)
  ) u_ovl (
    .clk         (clk),
    .rst_n       (rst_n),
    .overlay_clr (overlay_clr),
    .chip_addr   (chip_addr),
    .mem_addr    (mem_addr),
    .ovl_on      (ovl_on_w)
  );

  cag_rd_path #(
    .DATA_W (DATA_W)
  ) u_rd (
    .clk          (clk),
    .rst_n        (rst_n),
    .oe_n         (oe_n),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_data  (mem_rd_data),
    .hold         (in_ack_w),
    .mem_rd_req   (mem_rd_req),
    .rd_data      (cpu_rd_data)
  );
endmodule

// File: rtl/cpu_ack_gate_chk.sv
module cpu_ack_gate_chk #(
  parameter int                ADDR_W    = 22,
  parameter int                DATA_W    = 16,
  parameter int                OVL_W     = 18,
  parameter logic [ADDR_W-1:0] ROM_BASE  = 22'h3C0000,
  parameter int                WAIT_MODE = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              oe_n,
  input logic              ack_early_n,
  input logic [ADDR_W-1:0] chip_addr,
  input logic              overlay_clr,
  input logic              mem_rd_valid,
  input logic              dtack_n,
  input logic              mem_rd_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] cpu_rd_data,
  input logic [1:0]        state,
  input logic              ovl_on
);
  import cag_pkg::*;

  p_rst_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (dtack_n && !mem_rd_req));

  p_no_raw_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> dtack_n);

  p_enter_qualified_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && (oe_n || ack_early_n)) |=> (state == ST_IDLE));

  p_ack_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACK && !ack_early_n) |=> (state == ST_ACK));

  p_ack_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACK && ack_early_n) |=> (state == ST_IDLE));

  p_req_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |=> !mem_rd_req);

  p_req_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> !$past(oe_n));

  p_overlay_map_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovl_on && ((chip_addr >> OVL_W) == '0)) |-> (mem_addr == chip_addr + ROM_BASE));

  p_overlay_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(overlay_clr) |-> (mem_addr == chip_addr));

  p_data_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_ACK) |-> $stable(cpu_rd_data));

  generate
    if (WAIT_MODE == 0) begin : g_fixed_chk
      p_wait_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_IDLE && state == ST_WAIT) |=> (state == ST_WAIT));
    end else begin : g_ready_chk
      p_wait_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !mem_rd_valid) |=> (state == ST_WAIT));
    end
  endgenerate
endmodule

bind cpu_ack_gate cpu_ack_gate_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .OVL_W     (OVL_W),
  .ROM_BASE  (ROM_BASE),
  .WAIT_MODE (WAIT_MODE)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .oe_n         (oe_n),
  .ack_early_n  (ack_early_n),
  .chip_addr    (chip_addr),
  .overlay_clr  (overlay_clr),
  .mem_rd_valid (mem_rd_valid),
  .dtack_n      (dtack_n),
  .mem_rd_req   (mem_rd_req),
  .mem_addr     (mem_addr),
  .cpu_rd_data  (cpu_rd_data),
  .state        (state_w),
  .ovl_on       (ovl_on_w)
);

// File: tb/tb_cpu_ack_gate.sv
`timescale 1ns/1ps
module tb_cpu_ack_gate;
  localparam int ADDR_W = 22;
  localparam int DATA_W = 16;
  localparam int WAITC  = 2;

  logic              clk = 1'b0;
  logic              rst_n, oe_n, ack_n, ovl_clr, rd_valid;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] rd_data;

  logic              dtack_f, req_f, dtack_r, req_r;
  logic [ADDR_W-1:0] maddr_f, maddr_r;
  logic [DATA_W-1:0] data_f, data_r;

  int n_chk  = 0;
  int n_fail = 0;
  bit chk_en = 1'b0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  cpu_ack_gate #(.WAIT_MODE(0), .WAIT_CYCLES(WAITC)) dut (
    .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .ack_early_n(ack_n), .chip_addr(addr),
    .overlay_clr(ovl_clr), .mem_rd_valid(rd_valid), .mem_rd_data(rd_data),
    .dtack_n(dtack_f), .mem_rd_req(req_f), .mem_addr(maddr_f), .cpu_rd_data(data_f));

  cpu_ack_gate #(.WAIT_MODE(1), .WAIT_CYCLES(WAITC)) dut_rdy (
    .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .ack_early_n(ack_n), .chip_addr(addr),
    .overlay_clr(ovl_clr), .mem_rd_valid(rd_valid), .mem_rd_data(rd_data),
    .dtack_n(dtack_r), .mem_rd_req(req_r), .mem_addr(maddr_r), .cpu_rd_data(data_r));

  // behavioural expectation: 0 idle, 1 waiting, 2 acknowledging
  int              m_st  [2];
  int              m_cnt [2];
  logic [DATA_W-1:0] m_data [2];
  logic            m_req, m_oeq, m_ovl;

  function automatic logic [ADDR_W-1:0] f_addr(logic [ADDR_W-1:0] a, logic ovl);
    if (ovl && a < 22'h040000) return a + 22'h3C0000;
    return a;
  endfunction

  function automatic logic f_dtack(int st, logic ackn);
    return (st == 2) ? ackn : 1'b1;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        m_st[i] = 0; m_cnt[i] = 0; m_data[i] = '0;
      end
      m_req = 1'b0; m_oeq = 1'b1; m_ovl = 1'b1;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (rd_valid && m_st[i] != 2) m_data[i] = rd_data;
        case (m_st[i])
          0: if (!oe_n && !ack_n) begin m_st[i] = 1; m_cnt[i] = 0; end
          1: begin
               if (i == 0) begin
                 if (m_cnt[i] == WAITC - 1) m_st[i] = 2;
                 else m_cnt[i]++;
               end else if (rd_valid) m_st[i] = 2;
             end
          default: if (ack_n) m_st[i] = 0;
        endcase
      end
      m_req = m_oeq && !oe_n;
      m_oeq = oe_n;
      if (ovl_clr) m_ovl = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (chk_en && rst_n) begin
      chk("R4/R5 dtack fixed", {31'd0, dtack_f}, {31'd0, f_dtack(m_st[0], ack_n)});
      chk("R5/R6 dtack ready", {31'd0, dtack_r}, {31'd0, f_dtack(m_st[1], ack_n)});
      chk("R7 req", {30'd0, req_f, req_r}, {30'd0, m_req, m_req});
      chk("R8/R9 addr", {10'd0, maddr_f}, {10'd0, f_addr(addr, m_ovl)});
      chk("R10 data fixed", {16'd0, data_f}, {16'd0, m_data[0]});
      chk("R10 data ready", {16'd0, data_r}, {16'd0, m_data[1]});
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; oe_n = 1'b1; ack_n = 1'b1; ovl_clr = 1'b0;
    rd_valid = 1'b0; rd_data = '0; addr = '0;
    repeat (3) tick();
    // R1 reset state
    chk("R1 dtack", {30'd0, dtack_f, dtack_r}, 32'd3);
    chk("R1 req", {30'd0, req_f, req_r}, 32'd0);
    chk("R1 data", {data_f, data_r}, 32'd0);
    chk("R1 overlay", {10'd0, maddr_f}, 32'h3C0000);
    rst_n = 1'b1;
    chk_en = 1'b1;

    // R8 vector fetch and window edges
    addr = 22'd2;        #0.5 chk("R8 vec2", {10'd0, maddr_f}, 32'h3C0002);
    addr = 22'd4;        #0.2 chk("R8 vec4", {10'd0, maddr_r}, 32'h3C0004);
    addr = 22'h03FFFF;   #0.1 chk("R8 top", {10'd0, maddr_f}, 32'h3FFFFF);
    addr = 22'h040000;   #0.1 chk("R8 outside", {10'd0, maddr_f}, 32'h040000);
    tick();

    // R2/R3 early ack without output-enable
    oe_n = 1'b1; ack_n = 1'b0;
    for (int k = 0; k < 5; k++) begin
      tick();
      chk("R2 raw ack", {30'd0, dtack_f, dtack_r}, 32'd3);
    end
    ack_n = 1'b1;
    tick();

    // R4/R6/R7 qualified read
    addr = 22'd4; oe_n = 1'b0; ack_n = 1'b0;
    tick();
    chk("R4 wait1", {31'd0, dtack_f}, 32'd1);
    chk("R7 req pulse", {31'd0, req_f}, 32'd1);
    tick();
    chk("R4 wait2", {31'd0, dtack_f}, 32'd1);
    chk("R7 req single", {31'd0, req_f}, 32'd0);
    tick();
    chk("R4 ack", {31'd0, dtack_f}, 32'd0);
    chk("R6 still wait", {31'd0, dtack_r}, 32'd1);
    repeat (3) begin
      tick();
      chk("R6 stall", {31'd0, dtack_r}, 32'd1);
    end
    rd_valid = 1'b1; rd_data = 16'hBEEF;
    tick();
    rd_valid = 1'b0;
    chk("R6 ack", {31'd0, dtack_r}, 32'd0);
    chk("R10 capture", {16'd0, data_r}, 32'hBEEF);
    chk("R10 ignore in ack", {16'd0, data_f}, 32'h0);
    rd_valid = 1'b1; rd_data = 16'h1234;
    tick();
    rd_valid = 1'b0;
    chk("R10 hold", {16'd0, data_r}, 32'hBEEF);
    ack_n = 1'b1; #0.5
    chk("R5 release", {30'd0, dtack_f, dtack_r}, 32'd3);
    oe_n = 1'b1;
    tick();
    ack_n = 1'b0;
    tick();
    chk("R3 idle stays", {30'd0, dtack_f, dtack_r}, 32'd3);
    ack_n = 1'b1;

    // R9 overlay clear
    addr = 22'd2; ovl_clr = 1'b1; #0.5
    chk("R9 not yet", {10'd0, maddr_f}, 32'h3C0002);
    tick();
    ovl_clr = 1'b0;
    chk("R9 cleared", {10'd0, maddr_f}, 32'h2);
    tick();
    chk("R9 sticky", {10'd0, maddr_r}, 32'h2);

    // R1 reset restores overlay
    rst_n = 1'b0;
    repeat (2) tick();
    rst_n = 1'b1;
    chk("R1 overlay back", {10'd0, maddr_f}, 32'h3C0002);

    // random phase
    for (int n = 0; n < 5000; n++) begin
      tick();
      oe_n     = $urandom % 2;
      ack_n    = (($urandom % 4) == 0);
      rd_valid = (($urandom % 4) == 0);
      rd_data  = DATA_W'($urandom);
      addr     = ($urandom % 2) ? ADDR_W'($urandom % 32'h40000) : ADDR_W'($urandom);
      ovl_clr  = (n == 3000);
      if (n == 4200) rst_n = 1'b0;
      if (n == 4203) rst_n = 1'b1;
    end
    tick();
    done = 1'b1;
    summary();
  end
endmodule